// File: doc/BRIEF.md
# Bit-Serial Codec Command Port

This block sits behind a byte-wide host register window and turns host register accesses into a serial control stream for an audio converter. Reads have side effects. One read opens a transfer and another read closes it. While a transfer is open, every write to the data register sends one serial bit. That bit is bit 7 of the written byte. The low seven bits of the byte are ignored.

There are two converter targets, and each has its own select output. Reading the high-frequency register opens a 16-bit playback command. The upper byte of that word names the command (for example 0xA6 or 0xA7 for the left or right output level) and the lower byte carries the value. Reading the data register opens a 32-bit capture-level frame made of four bytes: mic level, the same mic level again, right line level, then left line level. Both word types go out most significant bit first, in the order the host writes the bits. Each accepted bit produces one serial clock pulse. When a full word is closed, the block raises a one-cycle strobe toward the converter. A word that is closed early is discarded, and no strobe is raised.

Top module: `codec_cmd_port`

## Requirements
- R1: After reset, pbSel, capSel, serClk, serData, frameStrobe and overflow are all 0.
- R2: A host read of address 0x38 opens a playback transfer, and a host read of address 0x2C opens a capture transfer. The matching select (pbSel or capSel) is 1 from the clock edge that samples the read, and the other select is 0.
- R3: A host read of address 0x28 ends any open transfer. From the clock edge that samples it, both selects and serClk are 0.
- R4: A host write to address 0x2C that is accepted during an open transfer does three things. It drives serData to bit 7 of the written byte on the next edge. It raises serClk on the following edge for exactly one cycle. It holds serData unchanged until the next accepted write. Bits 6..0 of the byte have no effect.
- R5: A data write is ignored, and produces no serClk pulse, when no transfer is open. It is also ignored when a pulse is still in progress, which covers the two cycles after an accepted write.
- R6: A playback word is 16 bits and a capture frame is 32 bits. The serial stream carries the accepted bits in exactly the order the host wrote them.
- R7: A data write made after the open transfer already holds its full word length produces no pulse and sets the sticky overflow output. overflow stays 1 until the next open read clears it.
- R8: A close read when exactly the full word has been received pulses frameStrobe for one cycle, and the selects drop in that same cycle. A close read with a partial word, or with no transfer open, pulses nothing.
- R9: An open read while a transfer is already open restarts the transfer with the newly selected target and discards the bits already received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 8 | Host byte address |
| hostRdEn | input | 1 | Host read strobe; takes priority over a write in the same cycle |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | 8 | Host write data; only bit 7 is used |
| pbSel | output | 1 | Playback converter select |
| capSel | output | 1 | Capture-level converter select |
| serClk | output | 1 | Serial clock, one pulse per accepted bit |
| serData | output | 1 | Serial data |
| frameStrobe | output | 1 | One-cycle pulse when a complete word is closed |
| overflow | output | 1 | Sticky flag for bits written beyond the word length |

## Verification
The bench sends words whose write bytes carry unrelated low bits. A design that used any bit other than bit 7 would then corrupt the serial stream, and the scoreboard would catch it.

It also targets the corner cases:
- It writes one bit past a full capture frame. A design without the word-length limit would emit a 33rd pulse and leave overflow clear.
- It closes a 9-bit playback word early. A design that strobed on every close would pulse frameStrobe here.
- It writes during a pulse already in progress. A design without the busy guard would emit an extra pulse.
- It re-opens mid-word and then sends a full 16-bit word. A design that kept its old bit count would overflow part way and skip the final strobe.

// File: rtl/codec_port_pkg.sv
package codec_port_pkg;

  typedef enum logic [1:0] {
    XF_IDLE = 2'd0,
    XF_PLAY = 2'd1,
    XF_CAP  = 2'd2
  } xferState_t;

  // Strobes from control to datapath, valid for one cycle each
  typedef struct packed {
    logic openXfer;
    logic closeXfer;
    logic shiftBit;
    logic bitVal;
    logic overBit;
    logic clkRise;
    logic clkFall;
    logic finish;
  } dpStrobe_t;

endpackage

// File: rtl/codec_port_ctrl.sv
module codec_port_ctrl
  import codec_port_pkg::*;
#(
  parameter int PB_BITS  = 16,
  parameter int CAP_BITS = 32,
  parameter int CNT_W    = 6,
  parameter logic [7:0] ADDR_DATA  = 8'h2C,
  parameter logic [7:0] ADDR_CLOSE = 8'h28,
  parameter logic [7:0] ADDR_PLAY  = 8'h38
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       hostAddr,
  input  logic             hostRdEn,
  input  logic             hostWrEn,
  input  logic             bitIn,
  input  logic [CNT_W-1:0] bitCount,
  output logic             pbSel,
  output logic             capSel,
  output dpStrobe_t        strobe
);

  localparam logic [CNT_W-1:0] PB_LEN  = CNT_W'(PB_BITS);
  localparam logic [CNT_W-1:0] CAP_LEN = CNT_W'(CAP_BITS);

  xferState_t       state;
  logic [1:0]       phase;
  logic             rdOpenPb, rdOpenCap, rdClose, bitWrite, frameFull;
  logic [CNT_W-1:0] curLen;

  always_comb begin
    rdOpenPb  = hostRdEn && (hostAddr == ADDR_PLAY);
    rdOpenCap = hostRdEn && (hostAddr == ADDR_DATA);
    rdClose   = hostRdEn && (hostAddr == ADDR_CLOSE);
    curLen    = (state == XF_CAP) ? CAP_LEN : PB_LEN;
    frameFull = (bitCount == curLen);
    bitWrite  = hostWrEn && !hostRdEn && (hostAddr == ADDR_DATA) &&
                (state != XF_IDLE) && (phase == 2'd0);

    strobe.openXfer  = rdOpenPb || rdOpenCap;
    strobe.closeXfer = rdClose;
    strobe.shiftBit  = bitWrite && !frameFull;
    strobe.overBit   = bitWrite && frameFull;
    strobe.bitVal    = bitIn;
    strobe.clkRise   = (phase == 2'd1) && !hostRdEn;
    strobe.clkFall   = (phase == 2'd2);
    strobe.finish    = rdClose && (state != XF_IDLE) && frameFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= XF_IDLE;
    end else if (rdOpenPb) begin
      state <= XF_PLAY;
    end else if (rdOpenCap) begin
      state <= XF_CAP;
    end else if (rdClose) begin
      state <= XF_IDLE;
    end
  end

  // Pulse sequencer: 1 = data set up, 2 = clock high, 0 = ready
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= 2'd0;
    end else if (strobe.openXfer || rdClose) begin
      phase <= 2'd0;
    end else begin
      case (phase)
        2'd0:    phase <= strobe.shiftBit ? 2'd1 : 2'd0;
        2'd1:    phase <= 2'd2;
        default: phase <= 2'd0;
      endcase
    end
  end

  assign pbSel  = (state == XF_PLAY);
  assign capSel = (state == XF_CAP);

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != XF_IDLE) |-> (bitCount <= curLen));

  // R5
  idle_no_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == XF_IDLE) |-> (phase == 2'd0));

endmodule

// File: rtl/codec_port_dp.sv
module codec_port_dp
  import codec_port_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  output logic [CNT_W-1:0] bitCount,
  output logic             serClk,
  output logic             serData,
  output logic             frameStrobe,
  output logic             overflow
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
    end else if (strobe.openXfer) begin
      bitCount <= '0;
    end else if (strobe.shiftBit) begin
      bitCount <= bitCount + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serData <= 1'b0;
    end else if (strobe.shiftBit) begin
      serData <= strobe.bitVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serClk <= 1'b0;
    end else if (strobe.openXfer || strobe.closeXfer || strobe.clkFall) begin
      serClk <= 1'b0;
    end else if (strobe.clkRise) begin
      serClk <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overflow    <= 1'b0;
      frameStrobe <= 1'b0;
    end else begin
      frameStrobe <= strobe.finish;
      if (strobe.openXfer) begin
        overflow <= 1'b0;
      end else if (strobe.overBit) begin
        overflow <= 1'b1;
      end
    end
  end

  // R4
  data_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serClk) |-> $stable(serData));

  // R4
  clk_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    serClk |=> !serClk);

  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe |=> !frameStrobe);

endmodule

// File: rtl/codec_cmd_port.sv
module codec_cmd_port
  import codec_port_pkg::*;
#(
  parameter int PB_BITS  = 16,
  parameter int CAP_BITS = 32,
  parameter logic [7:0] ADDR_DATA  = 8'h2C,
  parameter logic [7:0] ADDR_CLOSE = 8'h28,
  parameter logic [7:0] ADDR_PLAY  = 8'h38
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] hostAddr,
  input  logic       hostRdEn,
  input  logic       hostWrEn,
  input  logic [7:0] hostWrData,
  output logic       pbSel,
  output logic       capSel,
  output logic       serClk,
  output logic       serData,
  output logic       frameStrobe,
  output logic       overflow
);

  localparam int MAX_BITS = (CAP_BITS > PB_BITS) ? CAP_BITS : PB_BITS;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);

  dpStrobe_t        strobe;
  logic [CNT_W-1:0] bitCount;
  logic             unusedLowBits;

  assign unusedLowBits = ^hostWrData[6:0];

  codec_port_ctrl #(
    .PB_BITS(PB_BITS), .CAP_BITS(CAP_BITS), .CNT_W(CNT_W),
    .ADDR_DATA(ADDR_DATA), .ADDR_CLOSE(ADDR_CLOSE), .ADDR_PLAY(ADDR_PLAY)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostRdEn(hostRdEn),
    .hostWrEn(hostWrEn), .bitIn(hostWrData[7]), .bitCount(bitCount),
    .pbSel(pbSel), .capSel(capSel), .strobe(strobe)
  );

  codec_port_dp #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bitCount(bitCount),
    .serClk(serClk), .serData(serData), .frameStrobe(frameStrobe),
    .overflow(overflow)
  );

  // R3
  clk_needs_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    serClk |-> (pbSel || capSel));

  // R8
  strobe_at_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe |-> (!pbSel && !capSel && $past(pbSel || capSel)));

  // R2
  one_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pbSel && capSel));

endmodule

// File: tb/test_codec_cmd_port.sv
`timescale 1ns/1ps
module test_codec_cmd_port;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] hostAddr = 8'h00;
  logic       hostRdEn = 1'b0;
  logic       hostWrEn = 1'b0;
  logic [7:0] hostWrData = 8'h00;
  logic       pbSel, capSel, serClk, serData, frameStrobe, overflow;

  int compared = 0;
  int mismatched = 0;
  int pulseCount = 0;
  int strobeCount = 0;
  bit finished = 1'b0;
  bit prevSerClk = 1'b0;
  bit expQ[$];

  always #2 clk = ~clk;

  codec_cmd_port i_codec_cmd_port (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostRdEn(hostRdEn),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData), .pbSel(pbSel),
    .capSel(capSel), .serClk(serClk), .serData(serData),
    .frameStrobe(frameStrobe), .overflow(overflow)
  );

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: pops one expected bit at every serClk rise (R4, R6)
  always @(negedge clk) begin
    if (rstN) begin
      if (serClk && !prevSerClk) begin
        pulseCount++;
        if (expQ.size() == 0) begin
          check("R5 unexpected pulse", 1, 0);
        end else begin
          check("R6 serial bit", int'(serData), int'(expQ.pop_front()));
        end
      end
      if (frameStrobe) strobeCount++;
      prevSerClk = serClk;
    end
  end

  task automatic hostRead(logic [7:0] a);
    @(negedge clk);
    hostAddr = a; hostRdEn = 1'b1;
    @(negedge clk);
    hostRdEn = 1'b0;
    @(negedge clk);
    #1;
  endtask

  // expPulse: bit is expected on the wire; low bits are filler (R4)
  task automatic writeBit(bit b, bit expPulse);
    @(negedge clk);
    hostAddr = 8'h2C; hostWrEn = 1'b1;
    hostWrData = {b, b ? 7'h2A : 7'h7F};
    if (expPulse) expQ.push_back(b);
    @(negedge clk);
    hostWrEn = 1'b0;
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic sendWord(logic [31:0] w, int n);
    for (int i = n - 1; i >= 0; i--) writeBit(w[i], 1'b1);
  endtask

  initial begin
    int p0, s0;
    repeat (3) @(negedge clk);
    #1;
    // R1
    check("R1 pbSel", int'(pbSel), 0);
    check("R1 capSel", int'(capSel), 0);
    check("R1 serClk", int'(serClk), 0);
    check("R1 serData", int'(serData), 0);
    check("R1 frameStrobe", int'(frameStrobe), 0);
    check("R1 overflow", int'(overflow), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R5: write with nothing open
    p0 = pulseCount;
    writeBit(1'b1, 1'b0);
    check("R5 idle write", pulseCount, p0);

    // R2, R6: playback word, left level command
    hostRead(8'h38);
    check("R2 pbSel", int'(pbSel), 1);
    check("R2 capSel", int'(capSel), 0);
    p0 = pulseCount; s0 = strobeCount;
    sendWord(32'h0000_A65A, 16);
    check("R6 playback pulses", pulseCount - p0, 16);
    hostRead(8'h28);
    check("R3 pbSel after close", int'(pbSel), 0);
    check("R3 serClk after close", int'(serClk), 0);
    check("R8 full playback strobe", strobeCount - s0, 1);

    // R2, R5, R6, R7: capture frame with busy write and overflow
    hostRead(8'h2C);
    check("R2 capSel", int'(capSel), 1);
    check("R2 pbSel", int'(pbSel), 0);
    p0 = pulseCount; s0 = strobeCount;
    sendWord(32'h3C3C_91E7 >> 16, 16);
    // R5: second write lands while pulse in progress
    @(negedge clk);
    hostAddr = 8'h2C; hostWrEn = 1'b1; hostWrData = 8'h00;
    expQ.push_back(1'b0);
    @(negedge clk);
    hostWrData = 8'h80;
    @(negedge clk);
    hostWrEn = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    sendWord(32'h0000_91E7, 15);
    check("R5 busy write dropped", pulseCount - p0, 32);
    check("R7 overflow before extra", int'(overflow), 0);
    writeBit(1'b1, 1'b0);
    writeBit(1'b0, 1'b0);
    check("R7 extra bits no pulse", pulseCount - p0, 32);
    check("R7 overflow set", int'(overflow), 1);
    hostRead(8'h28);
    check("R3 capSel after close", int'(capSel), 0);
    check("R8 full capture strobe", strobeCount - s0, 1);
    check("R7 overflow sticky", int'(overflow), 1);

    // R7 clear, R8 partial abort
    hostRead(8'h38);
    check("R7 overflow cleared on open", int'(overflow), 0);
    s0 = strobeCount;
    sendWord(32'h0000_0155, 9);
    hostRead(8'h28);
    check("R8 partial no strobe", strobeCount - s0, 0);
    check("R3 pbSel after abort", int'(pbSel), 0);

    // R8: close with nothing open
    hostRead(8'h28);
    check("R8 idle close no strobe", strobeCount - s0, 0);

    // R9: restart from capture to playback mid-word
    hostRead(8'h2C);
    sendWord(32'h0000_0013, 5);
    hostRead(8'h38);
    check("R9 pbSel after restart", int'(pbSel), 1);
    check("R9 capSel after restart", int'(capSel), 0);
    p0 = pulseCount; s0 = strobeCount;
    sendWord(32'h0000_A7C3, 16);
    check("R9 full word after restart", pulseCount - p0, 16);
    check("R9 no overflow after restart", int'(overflow), 0);
    hostRead(8'h28);
    check("R9 strobe after restart", strobeCount - s0, 1);

    check("R6 scoreboard drained", expQ.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule